// File: doc/BRIEF.md
# Adjustable Microframe Timer with Offset Snapshot

This block keeps time for a USB high-speed host by counting microframes. An offset counter advances once per clock, where each clock stands for eight high-speed bit times. It runs from zero up to a limit and then wraps to zero. Each wrap advances a 14-bit frame index and raises a one-cycle start strobe. With the reset trim the limit is 7499, which gives 7500 units (125 us) per microframe.

A 6-bit trim value corrects for an inaccurate reference clock. It can be written only while the controller reports itself halted. The timer picks up the trimmed limit only when a microframe ends, so a trim never cuts short the microframe that is in progress.

A single sample pulse takes a consistent picture of the frame index and the offset into one 32-bit read-only word. Software can then read both from that word without tearing.

Top module: `uframe_timer`

## Requirements
- R1: After reset, frame_idx_o is 0, snap_o is 0, sof_o is low and the trim value is 0x20, so the first microframe run from offset 0 lasts 7500 clocks.
- R2: A trim write (adj_we_i high at a clock edge) is accepted only when halted_i is 1 at that edge. A write made while halted_i is 0 does not change the length of any later microframe.
- R3: While running, the offset rises by one each clock from 0 to the limit L = 7499 + 2*(trim - 32), with trim unsigned 6-bit. L is therefore 7435 for trim 0 and 7561 for trim 63, and a microframe lasts L+1 clocks.
- R4: At the edge where the offset equals L and halted_i is 0, the offset becomes 0 and frame_idx_o increments modulo 2^14. In the following cycle sof_o is high, and it is high for exactly that one cycle.
- R5: At any edge where halted_i is 1, the offset and frame_idx_o hold their values and sof_o is low in the next cycle.
- R6: A trim change is adopted into the timer only at the wrap edge of R4. The microframe in progress when the write happens keeps the limit it started with.
- R7: When sample_i is high at an edge, then from the next cycle onward snap_o[29:16] holds the frame index from before that edge and snap_o[12:0] holds the offset from before that edge. Without sample_i, snap_o does not change.
- R8: snap_o bits 31:30 and 15:13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period is one unit of eight high-speed bit times |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halted_i | input | 1 | 1 = controller halted: timer frozen, trim writable |
| adj_we_i | input | 1 | Trim write enable |
| adj_wdata_i | input | 6 | Trim value to write |
| sample_i | input | 1 | Snapshot request |
| frame_idx_o | output | 14 | Current frame index |
| sof_o | output | 1 | One-cycle microframe start strobe |
| snap_o | output | 32 | Snapshot word: index in 29:16, offset in 12:0, other bits 0 |

## Verification
The bench measures whole microframe lengths at both trim extremes. A limit formula with the wrong sign or step size would show 7500 +/- some other count instead of 7436 or 7562. It writes the trim while running and expects the next microframe to stay at 7500, which catches a design that ignores the halt gate. It also writes the trim while halted at offset 0 and resumes. A design that adopts the new limit at once, instead of at the next wrap, would shorten the microframe in progress. Snapshots are taken at a known offset and while halted, so a design that captures after the counter steps would read the offset as one too high.

// File: rtl/uft_pkg.sv
package uft_pkg;
    localparam int UFT_IDX_W    = 14;
    localparam int UFT_OFS_W    = 13;
    localparam int UFT_ADJ_W    = 6;
    localparam int UFT_ADJ_NOM  = 32;
    localparam int UFT_BASE_LIM = 7499;
    localparam int UFT_STEP     = 2;
    localparam int UFT_SNAP_W   = 32;
    localparam int UFT_IDX_LSB  = 16;

    // Offset limit for a given trim value.
    function automatic int uft_limit(input int adj, input int base, input int step, input int nom);
        return base + step * (adj - nom);
    endfunction
endpackage

// File: rtl/uft_adjust.sv
module uft_adjust
    import uft_pkg::*;
#(
    parameter int ADJ_W    = UFT_ADJ_W,
    parameter int OFS_W    = UFT_OFS_W,
    parameter int ADJ_NOM  = UFT_ADJ_NOM,
    parameter int BASE_LIM = UFT_BASE_LIM,
    parameter int STEP     = UFT_STEP
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             halted_i,
    input  logic             we_i,
    input  logic [ADJ_W-1:0] wdata_i,
    output logic [ADJ_W-1:0] adj_o,
    output logic [OFS_W-1:0] lim_o
);
    localparam logic [ADJ_W-1:0] ADJ_RST = ADJ_W'(ADJ_NOM);

    logic [ADJ_W-1:0] adj_d, adj_q;

    always_comb begin
        adj_d = adj_q;
        if (we_i && halted_i) begin
            adj_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            adj_q <= ADJ_RST;
        end else begin
            adj_q <= adj_d;
        end
    end

    assign adj_o = adj_q;
    // Limit the timer will adopt at its next wrap.
    assign lim_o = OFS_W'(uft_limit(int'(adj_q), BASE_LIM, STEP, ADJ_NOM));
endmodule

// File: rtl/uft_timer.sv
module uft_timer
    import uft_pkg::*;
#(
    parameter int IDX_W    = UFT_IDX_W,
    parameter int OFS_W    = UFT_OFS_W,
    parameter int ADJ_NOM  = UFT_ADJ_NOM,
    parameter int BASE_LIM = UFT_BASE_LIM,
    parameter int STEP     = UFT_STEP
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [OFS_W-1:0] lim_next_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [OFS_W-1:0] lim_o,
    output logic             sof_o
);
    localparam logic [OFS_W-1:0] LIM_RST =
        OFS_W'(uft_limit(ADJ_NOM, BASE_LIM, STEP, ADJ_NOM));

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic [IDX_W-1:0] idx;
        logic [OFS_W-1:0] lim;
        logic             sof;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sof = 1'b0;
        if (run_i) begin
            if (st_q.ofs == st_q.lim) begin
                st_d.ofs = '0;
                st_d.idx = st_q.idx + IDX_W'(1);
                st_d.lim = lim_next_i;
                st_d.sof = 1'b1;
            end else begin
                st_d.ofs = st_q.ofs + OFS_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ofs <= '0;
            st_q.idx <= '0;
            st_q.lim <= LIM_RST;
            st_q.sof <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ofs_o = st_q.ofs;
    assign idx_o = st_q.idx;
    assign lim_o = st_q.lim;
    assign sof_o = st_q.sof;
endmodule

// File: rtl/uft_snapshot.sv
module uft_snapshot
    import uft_pkg::*;
#(
    parameter int IDX_W   = UFT_IDX_W,
    parameter int OFS_W   = UFT_OFS_W,
    parameter int SNAP_W  = UFT_SNAP_W,
    parameter int IDX_LSB = UFT_IDX_LSB
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sample_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [SNAP_W-1:0] snap_o
);
    logic [SNAP_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (sample_i) begin
            snap_d                     = '0;
            snap_d[IDX_LSB +: IDX_W]   = idx_i;
            snap_d[0 +: OFS_W]         = ofs_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign snap_o = snap_q;
endmodule

// File: rtl/uframe_timer.sv
module uframe_timer
    import uft_pkg::*;
#(
    parameter int IDX_W    = UFT_IDX_W,
    parameter int OFS_W    = UFT_OFS_W,
    parameter int ADJ_W    = UFT_ADJ_W,
    parameter int ADJ_NOM  = UFT_ADJ_NOM,
    parameter int BASE_LIM = UFT_BASE_LIM,
    parameter int STEP     = UFT_STEP,
    parameter int SNAP_W   = UFT_SNAP_W,
    parameter int IDX_LSB  = UFT_IDX_LSB
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              halted_i,
    input  logic              adj_we_i,
    input  logic [ADJ_W-1:0]  adj_wdata_i,
    input  logic              sample_i,
    output logic [IDX_W-1:0]  frame_idx_o,
    output logic              sof_o,
    output logic [SNAP_W-1:0] snap_o
);
    logic [ADJ_W-1:0] adj_q;
    logic [OFS_W-1:0] lim_next;
    logic [OFS_W-1:0] lim_q;
    logic [OFS_W-1:0] ofs_q;

    uft_adjust #(
        .ADJ_W(ADJ_W), .OFS_W(OFS_W), .ADJ_NOM(ADJ_NOM),
        .BASE_LIM(BASE_LIM), .STEP(STEP)
    ) u_adj (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .halted_i (halted_i),
        .we_i     (adj_we_i),
        .wdata_i  (adj_wdata_i),
        .adj_o    (adj_q),
        .lim_o    (lim_next)
    );

    uft_timer #(
        .IDX_W(IDX_W), .OFS_W(OFS_W), .ADJ_NOM(ADJ_NOM),
        .BASE_LIM(BASE_LIM), .STEP(STEP)
    ) u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (!halted_i),
        .lim_next_i (lim_next),
        .ofs_o      (ofs_q),
        .idx_o      (frame_idx_o),
        .lim_o      (lim_q),
        .sof_o      (sof_o)
    );

    uft_snapshot #(
        .IDX_W(IDX_W), .OFS_W(OFS_W), .SNAP_W(SNAP_W), .IDX_LSB(IDX_LSB)
    ) u_snap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (sample_i),
        .idx_i    (frame_idx_o),
        .ofs_i    (ofs_q),
        .snap_o   (snap_o)
    );
endmodule

// File: rtl/uft_checker.sv
module uft_checker
    import uft_pkg::*;
#(
    parameter int IDX_W   = UFT_IDX_W,
    parameter int OFS_W   = UFT_OFS_W,
    parameter int ADJ_W   = UFT_ADJ_W,
    parameter int SNAP_W  = UFT_SNAP_W,
    parameter int IDX_LSB = UFT_IDX_LSB
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              halted_i,
    input logic              sample_i,
    input logic              sof_o,
    input logic [IDX_W-1:0]  frame_idx_o,
    input logic [SNAP_W-1:0] snap_o,
    input logic [ADJ_W-1:0]  adj_q,
    input logic [OFS_W-1:0]  ofs_q,
    input logic [OFS_W-1:0]  lim_q
);
    localparam logic [SNAP_W-1:0] LIVE_MASK =
        ((SNAP_W'(1) << OFS_W) - SNAP_W'(1)) |
        (((SNAP_W'(1) << IDX_W) - SNAP_W'(1)) << IDX_LSB);

    a_r2_trim_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !halted_i |=> $stable(adj_q));

    a_r3_ofs_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ofs_q <= lim_q);

    a_r4_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |-> frame_idx_o == $past(frame_idx_o) + IDX_W'(1));

    a_r4_sof_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |=> !sof_o);

    a_r5_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halted_i |=> ($stable(frame_idx_o) && $stable(ofs_q) && !sof_o));

    a_r6_lim_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sof_o |-> $stable(lim_q));

    a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_i |=> (snap_o[IDX_LSB +: IDX_W] == $past(frame_idx_o)) &&
                     (snap_o[0 +: OFS_W] == $past(ofs_q)));

    a_r7_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_i |=> $stable(snap_o));

    a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (snap_o & ~LIVE_MASK) == '0);
endmodule

bind uframe_timer uft_checker #(
    .IDX_W(IDX_W), .OFS_W(OFS_W), .ADJ_W(ADJ_W), .SNAP_W(SNAP_W), .IDX_LSB(IDX_LSB)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halted_i    (halted_i),
    .sample_i    (sample_i),
    .sof_o       (sof_o),
    .frame_idx_o (frame_idx_o),
    .snap_o      (snap_o),
    .adj_q       (adj_q),
    .ofs_q       (ofs_q),
    .lim_q       (lim_q)
);

// File: tb/sim_uframe_timer.sv
`timescale 1ns/1ps
module sim_uframe_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halted = 1'b1;
    logic        we = 1'b0;
    logic [5:0]  wdata = '0;
    logic        sample = 1'b0;
    logic [13:0] idx;
    logic        sof;
    logic [31:0] snap;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uframe_timer u0 (
        .clk_i(clk), .rst_ni(rst_n), .halted_i(halted), .adj_we_i(we),
        .adj_wdata_i(wdata), .sample_i(sample),
        .frame_idx_o(idx), .sof_o(sof), .snap_o(snap)
    );

    // Behavioural reference
    int          m_ofs, m_idx, m_adj, m_max;
    bit          m_sof;
    logic [31:0] m_snap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ofs = 0; m_idx = 0; m_adj = 32; m_max = 7499; m_sof = 0; m_snap = '0;
        end else begin
            if (sample) m_snap = (32'(m_idx) << 16) | 32'(m_ofs);
            m_sof = 0;
            if (!halted) begin
                if (m_ofs == m_max) begin
                    m_ofs = 0;
                    m_idx = (m_idx + 1) % 16384;
                    m_max = 7499 + 2 * (m_adj - 32);
                    m_sof = 1;
                end else begin
                    m_ofs = m_ofs + 1;
                end
            end
            if (we && halted) m_adj = int'(wdata);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 frame index vs model", int'(idx), m_idx);
            chk("R4 start strobe vs model", int'(sof), int'(m_sof));
            chk("R7 snapshot vs model", int'(snap), int'(m_snap));
        end
    end

    task automatic wait_sof();
        while (!sof) @(negedge clk);
    endtask

    task automatic measure(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!sof);
    endtask

    initial begin
        int len;
        int idx_at;
        repeat (3) @(negedge clk);
        chk("R1 reset frame index", int'(idx), 0);
        chk("R1 reset strobe", int'(sof), 0);
        chk("R1 reset snapshot", int'(snap), 0);
        rst_n = 1'b1;

        // Halted: nothing moves; sample reads zero offset
        repeat (20) @(negedge clk);
        chk("R5 index held while halted", int'(idx), 0);
        sample = 1'b1; @(negedge clk); sample = 1'b0;
        chk("R7 snapshot while halted", int'(snap), 0);

        // Run with reset trim: first microframe from offset 0
        halted = 1'b0;
        measure(len);
        chk("R1 first microframe length", len, 7500);
        chk("R4 index after first wrap", int'(idx), 1);

        // Snapshot at known offset 100
        repeat (100) @(negedge clk);
        idx_at = int'(idx);
        sample = 1'b1; @(negedge clk); sample = 1'b0;
        chk("R7 captured offset", int'(snap[12:0]), 100);
        chk("R7 captured index", int'(snap[29:16]), idx_at);
        chk("R8 reserved bits", int'({snap[31:30], snap[15:13]}), 0);
        repeat (50) @(negedge clk);
        chk("R7 snapshot held", int'(snap[12:0]), 100);

        // Write while running is ignored
        we = 1'b1; wdata = 6'd0; @(negedge clk); we = 1'b0;
        wait_sof();
        measure(len);
        chk("R2 write while running ignored", len, 7500);

        // Halt at boundary, trim to 0, resume
        halted = 1'b1; we = 1'b1; wdata = 6'd0;
        @(negedge clk); we = 1'b0;
        idx_at = int'(idx);
        repeat (9) @(negedge clk);
        chk("R5 index held during halt", int'(idx), idx_at);
        halted = 1'b0;
        measure(len);
        chk("R6 in-progress microframe keeps old length", len, 7500);
        measure(len);
        chk("R3 length with trim 0", len, 7436);

        // Halt at boundary, trim to 63, resume
        halted = 1'b1; we = 1'b1; wdata = 6'd63;
        @(negedge clk); we = 1'b0;
        repeat (5) @(negedge clk);
        halted = 1'b0;
        measure(len);
        chk("R6 in-progress microframe keeps trim-0 length", len, 7436);
        measure(len);
        chk("R3 length with trim 63", len, 7562);
        measure(len);
        chk("R3 trim 63 repeats", len, 7562);

        // Halt mid-frame: offset held, snapshot shows it
        repeat (200) @(negedge clk);
        halted = 1'b1;
        @(negedge clk);
        sample = 1'b1; @(negedge clk); sample = 1'b0;
        chk("R5 offset held mid-frame", int'(snap[12:0]), 200);
        repeat (10) @(negedge clk);
        sample = 1'b1; @(negedge clk); sample = 1'b0;
        chk("R5 offset still held", int'(snap[12:0]), 200);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule